// File: doc/BRIEF.md
# JTAG Chain Structure Probe

This block is a small JTAG host engine. It drives TCK, TMS and TDI toward a scan chain whose wiring is known but whose contents are not. It samples TDO and works out three structural numbers: how many TAP controllers sit in the chain, the summed instruction-register length, and the length of the data path that is currently selected. Every measurement uses the same method. The engine floods the shift path with a known fill value, sends one marker bit of the opposite value, and counts shift cycles until the marker comes back on TDO.

A measurement is started by a one-cycle `start` strobe with an operation code. The engine runs the TAP state sequence by itself. When it finishes, it raises `done` for one cycle. On that cycle the result for the chosen operation, its valid bit and a timeout flag are all up to date. TCK runs at a quarter of the system clock.

A TAP count first loads every instruction register with ones, so that all devices select BYPASS. It then clears the bypass bits with zeros and pushes ones until the first one is seen. The instruction and data length measurements stay in Shift-IR or Shift-DR respectively. A data length measurement never touches the instruction registers, so it reports the path the chain has selected at the time it runs.

Top module: `jchain_probe`

## Requirements
- R1: With `op` = 0 (TAP count), the engine enters Shift-IR and shifts FILL_LEN+1 ones. It then enters Shift-DR, shifts FILL_LEN zeros and then ones. `taps` reports the number of shifts from the first one up to the shift on which a 1 is first sampled on TDO, which equals the number of TAPs, and `taps_vld` is set.
- R2: With `op` = 1 (instruction length), the engine enters Shift-IR, shifts FILL_LEN ones, one zero, then ones. `ir_bits` reports how many shifts after the zero pass until a 0 is sampled on TDO, which is the summed IR length, and `ir_vld` is set.
- R3: With `op` = 2 (data length), the same marker scheme runs in Shift-DR without passing through Capture-IR or Update-IR. `dr_bits` therefore reports the currently selected data path: the sum of data-register lengths after a chain reset, or the TAP count once every device holds BYPASS. `dr_vld` is set.
- R4: If the marker has not been sampled by the MAX_COUNT-th shift after it, the measurement stops. `timeout` is 1, and the result and valid bit of that operation are 0. A measurement that finds its marker leaves `timeout` at 0.
- R5: A length of exactly MAX_COUNT is reported as valid. A length of MAX_COUNT+1 ends in timeout.
- R6: TCK is low whenever the engine is idle. While the engine runs, TCK is high for exactly 2 clock cycles and low for at least 2. TMS and TDI change only while TCK is low, and never on the cycle TCK rises.
- R7: Every TMS sequence begins with a 0, so a measurement works whether the chain starts in Test-Logic-Reset or Run-Test/Idle. Each shift phase leaves through Exit1 and Update, and every measurement ends with the chain in Run-Test/Idle.
- R8: `done` is a single-cycle pulse. On that cycle the result, valid bit and `timeout` for the finished operation are already updated.
- R9: A `start` seen while a measurement runs is ignored. A `start` with `op` = 3 is ignored: no TCK edge and no `done` follow.
- R10: A measurement writes only its own result and valid bit. The other two results keep their values.
- R11: After reset, TCK, TMS, TDI, `done`, `timeout`, all results and all valid bits are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | One-cycle request to begin a measurement |
| op | input | 2 | Operation: 0 TAP count, 1 IR length, 2 DR length, 3 none |
| tck | output | 1 | JTAG test clock, clk/4 while running |
| tms | output | 1 | JTAG mode select |
| tdi | output | 1 | JTAG data toward the chain |
| tdo | input | 1 | JTAG data returning from the chain |
| done | output | 1 | One-cycle completion pulse |
| timeout | output | 1 | Last measurement did not see its marker |
| taps | output | clog2(MAX_COUNT+1) | Number of TAPs found |
| taps_vld | output | 1 | `taps` holds a measured value |
| ir_bits | output | clog2(MAX_COUNT+1) | Summed instruction-register length |
| ir_vld | output | 1 | `ir_bits` holds a measured value |
| dr_bits | output | clog2(MAX_COUNT+1) | Length of the selected data path |
| dr_vld | output | 1 | `dr_bits` holds a measured value |

## Verification
The bench models a chain of one to four TAPs, each with its own instruction and data-register length, and sweeps eight such chains. Each chain goes through the order data, instruction, data, count. The first data measurement sees the data registers selected after reset. The second sees only bypass bits, and the two differ only if the engine leaves the instruction registers alone during a data measurement. TDO is also held stuck at 1 and at 0 to provoke a timeout for each marker polarity. A single data register of exactly MAX_COUNT and of MAX_COUNT+1 bits separates the last reportable length from the first timeout. A start during a run and a start with the unused code show that requests are ignored while the engine is busy.

// File: rtl/jcp_pkg.sv
package jcp_pkg;

  typedef enum logic [1:0] {
    OP_TAPS  = 2'd0,
    OP_IRLEN = 2'd1,
    OP_DRLEN = 2'd2,
    OP_NONE  = 2'd3
  } op_e;

  typedef enum logic [2:0] {
    SQ_IDLE,
    SQ_NAV,
    SQ_FILL,
    SQ_MARK,
    SQ_EXIT,
    SQ_UPD,
    SQ_RTI
  } sq_e;

endpackage

// File: rtl/jcp_tck_gen.sv
// Bit pacer: four system clocks per TCK period.
// Phase 0 loads TMS/TDI, phase 1 raises TCK, phase 3 drops TCK and ends the bit.
module jcp_tck_gen (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic tms_nxt,
  input  logic tdi_nxt,
  output logic tck,
  output logic tms,
  output logic tdi,
  output logic bit_end
);

  logic [1:0] ph_q, ph_d;
  logic       tck_d, tms_d, tdi_d;

  always_comb begin
    ph_d  = 2'd0;
    tck_d = tck;
    tms_d = tms;
    tdi_d = tdi;
    if (run) begin
      ph_d = ph_q + 2'd1;
      case (ph_q)
        2'd0: begin
          tms_d = tms_nxt;
          tdi_d = tdi_nxt;
        end
        2'd1:    tck_d = 1'b1;
        2'd3:    tck_d = 1'b0;
        default: ;
      endcase
    end
  end

  assign bit_end = run && (ph_q == 2'd3);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q <= 2'd0;
      tck  <= 1'b0;
      tms  <= 1'b0;
      tdi  <= 1'b0;
    end else begin
      ph_q <= ph_d;
      tck  <= tck_d;
      tms  <= tms_d;
      tdi  <= tdi_d;
    end
  end

  AST_SETUP_BEFORE_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tck) |-> ($stable(tms) && $stable(tdi))); // R6

  AST_TCK_LOW_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !run |-> !tck); // R6

endmodule

// File: rtl/jcp_seq.sv
// Measurement sequencer: TMS navigation, fill, marker count, exit.
module jcp_seq
  import jcp_pkg::*;
#(
  parameter int FILL_LEN  = 1024,
  parameter int MAX_COUNT = 1024,
  localparam int CNT_W    = $clog2(MAX_COUNT + 1),
  localparam int FILL_W   = $clog2(FILL_LEN + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  op_e              op_in,
  input  logic             bit_end,
  input  logic             tdo,
  output logic             busy,
  output logic             tms_nxt,
  output logic             tdi_nxt,
  output logic             fin,
  output logic             found,
  output logic [CNT_W-1:0] count,
  output op_e              op_q
);

  // TMS walk to Shift-IR (0,1,1,0,0) and to Shift-DR (0,1,0,0), bit i is step i
  localparam logic [4:0] NAV_IR  = 5'b00110;
  localparam logic [4:0] NAV_DR  = 5'b00010;
  localparam logic [2:0] LAST_IR = 3'd4;
  localparam logic [2:0] LAST_DR = 3'd3;

  sq_e              st_q, st_d;
  op_e              op_d;
  logic             pass_ir_q, pass_ir_d;
  logic [2:0]       nav_q, nav_d;
  logic [FILL_W-1:0] fcnt_q, fcnt_d;
  logic [CNT_W-1:0] mcnt_q, mcnt_d;
  logic             found_d;
  logic [CNT_W-1:0] count_d;

  logic fill_val, marker, skip_mark;
  logic [2:0] nav_last;

  assign skip_mark = pass_ir_q && (op_q == OP_TAPS);
  assign fill_val  = !(op_q == OP_TAPS && !pass_ir_q);
  assign marker    = !fill_val;
  assign nav_last  = pass_ir_q ? LAST_IR : LAST_DR;
  assign busy      = (st_q != SQ_IDLE);

  // next state
  always_comb begin
    st_d      = st_q;
    op_d      = op_q;
    pass_ir_d = pass_ir_q;
    nav_d     = nav_q;
    fcnt_d    = fcnt_q;
    mcnt_d    = mcnt_q;
    found_d   = found;
    count_d   = count;
    fin       = 1'b0;
    unique case (st_q)
      SQ_IDLE: begin
        if (start && op_in != OP_NONE) begin
          st_d      = SQ_NAV;
          op_d      = op_in;
          pass_ir_d = (op_in != OP_DRLEN);
          nav_d     = 3'd0;
          found_d   = 1'b0;
          count_d   = '0;
        end
      end
      SQ_NAV: begin
        if (bit_end) begin
          if (nav_q == nav_last) begin
            st_d   = SQ_FILL;
            fcnt_d = '0;
          end else begin
            nav_d = nav_q + 3'd1;
          end
        end
      end
      SQ_FILL: begin
        if (bit_end) begin
          if (fcnt_q == FILL_W'(FILL_LEN - 1)) begin
            st_d   = skip_mark ? SQ_EXIT : SQ_MARK;
            mcnt_d = '0;
          end else begin
            fcnt_d = fcnt_q + 1'b1;
          end
        end
      end
      SQ_MARK: begin
        if (bit_end) begin
          if (tdo == marker) begin
            found_d = 1'b1;
            count_d = mcnt_q;
            st_d    = SQ_EXIT;
          end else if (mcnt_q == CNT_W'(MAX_COUNT)) begin
            st_d = SQ_EXIT;
          end else begin
            mcnt_d = mcnt_q + 1'b1;
          end
        end
      end
      SQ_EXIT: begin
        if (bit_end) st_d = SQ_UPD;
      end
      SQ_UPD: begin
        if (bit_end) begin
          if (skip_mark) begin
            pass_ir_d = 1'b0;
            nav_d     = 3'd0;
            st_d      = SQ_NAV;
          end else begin
            st_d = SQ_RTI;
          end
        end
      end
      SQ_RTI: begin
        if (bit_end) begin
          st_d = SQ_IDLE;
          fin  = 1'b1;
        end
      end
      default: st_d = SQ_IDLE;
    endcase
  end

  // pin values for the bit of the current state
  always_comb begin
    tms_nxt = 1'b0;
    tdi_nxt = 1'b0;
    unique case (st_q)
      SQ_NAV:  tms_nxt = pass_ir_q ? NAV_IR[nav_q] : NAV_DR[nav_q];
      SQ_FILL: tdi_nxt = fill_val;
      SQ_MARK: tdi_nxt = (mcnt_q == '0) ? marker : 1'b1;
      SQ_EXIT: begin
        tms_nxt = 1'b1;
        tdi_nxt = 1'b1;
      end
      SQ_UPD:  tms_nxt = 1'b1;
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q      <= SQ_IDLE;
      op_q      <= OP_TAPS;
      pass_ir_q <= 1'b0;
      nav_q     <= 3'd0;
      fcnt_q    <= '0;
      mcnt_q    <= '0;
      found     <= 1'b0;
      count     <= '0;
    end else begin
      st_q      <= st_d;
      op_q      <= op_d;
      pass_ir_q <= pass_ir_d;
      nav_q     <= nav_d;
      fcnt_q    <= fcnt_d;
      mcnt_q    <= mcnt_d;
      found     <= found_d;
      count     <= count_d;
    end
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == SQ_MARK) |-> (mcnt_q <= CNT_W'(MAX_COUNT))); // R4

  AST_BUSY_HOLDS_OP: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start) |=> (op_q == $past(op_q))); // R9

  AST_UNUSED_OP_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && start && op_in == OP_NONE) |=> !busy); // R9

endmodule

// File: rtl/jcp_result.sv
// Result registers: one value and valid bit per operation, timeout and done.
module jcp_result
  import jcp_pkg::*;
#(
  parameter int CNT_W = 11
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fin,
  input  logic             found,
  input  op_e              op,
  input  logic [CNT_W-1:0] count,
  output logic             done,
  output logic             timeout,
  output logic [CNT_W-1:0] taps,
  output logic             taps_vld,
  output logic [CNT_W-1:0] ir_bits,
  output logic             ir_vld,
  output logic [CNT_W-1:0] dr_bits,
  output logic             dr_vld
);

  logic [CNT_W-1:0] value;
  logic             en_taps, en_ir, en_dr;

  assign value   = found ? count : '0;
  assign en_taps = fin && (op == OP_TAPS);
  assign en_ir   = fin && (op == OP_IRLEN);
  assign en_dr   = fin && (op == OP_DRLEN);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done     <= 1'b0;
      timeout  <= 1'b0;
      taps     <= '0;
      taps_vld <= 1'b0;
      ir_bits  <= '0;
      ir_vld   <= 1'b0;
      dr_bits  <= '0;
      dr_vld   <= 1'b0;
    end else begin
      done <= fin;
      if (fin) timeout <= !found;
      if (en_taps) begin
        taps     <= value;
        taps_vld <= found;
      end
      if (en_ir) begin
        ir_bits <= value;
        ir_vld  <= found;
      end
      if (en_dr) begin
        dr_bits <= value;
        dr_vld  <= found;
      end
    end
  end

  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R8

  AST_TIMEOUT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (done && timeout) |->
      ((op == OP_TAPS  && taps == '0    && !taps_vld) ||
       (op == OP_IRLEN && ir_bits == '0 && !ir_vld)   ||
       (op == OP_DRLEN && dr_bits == '0 && !dr_vld))); // R4

  AST_TAPS_ONLY_AT_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(taps) |-> (done && op == OP_TAPS)); // R10

  AST_IR_ONLY_AT_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(ir_bits) |-> (done && op == OP_IRLEN)); // R10

endmodule

// File: rtl/jchain_probe.sv
module jchain_probe
  import jcp_pkg::*;
#(
  parameter int FILL_LEN  = 1024,
  parameter int MAX_COUNT = 1024
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             start,
  input  logic [1:0]                       op,
  output logic                             tck,
  output logic                             tms,
  output logic                             tdi,
  input  logic                             tdo,
  output logic                             done,
  output logic                             timeout,
  output logic [$clog2(MAX_COUNT+1)-1:0]   taps,
  output logic                             taps_vld,
  output logic [$clog2(MAX_COUNT+1)-1:0]   ir_bits,
  output logic                             ir_vld,
  output logic [$clog2(MAX_COUNT+1)-1:0]   dr_bits,
  output logic                             dr_vld
);

  localparam int CNT_W = $clog2(MAX_COUNT + 1);

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rsync_q;
  logic       srst_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= 2'b00;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign srst_n = rsync_q[1];

  op_e              op_in, op_q;
  logic             busy, tms_nxt, tdi_nxt, bit_end, fin, found;
  logic [CNT_W-1:0] count;

  assign op_in = op_e'(op);

  jcp_seq #(
    .FILL_LEN  (FILL_LEN),
    .MAX_COUNT (MAX_COUNT)
  ) u_seq (
    .clk     (clk),
    .rst_n   (srst_n),
    .start   (start),
    .op_in   (op_in),
    .bit_end (bit_end),
    .tdo     (tdo),
    .busy    (busy),
    .tms_nxt (tms_nxt),
    .tdi_nxt (tdi_nxt),
    .fin     (fin),
    .found   (found),
    .count   (count),
    .op_q    (op_q)
  );

  jcp_tck_gen u_tck (
    .clk     (clk),
    .rst_n   (srst_n),
    .run     (busy),
    .tms_nxt (tms_nxt),
    .tdi_nxt (tdi_nxt),
    .tck     (tck),
    .tms     (tms),
    .tdi     (tdi),
    .bit_end (bit_end)
  );

  jcp_result #(
    .CNT_W (CNT_W)
  ) u_res (
    .clk      (clk),
    .rst_n    (srst_n),
    .fin      (fin),
    .found    (found),
    .op       (op_q),
    .count    (count),
    .done     (done),
    .timeout  (timeout),
    .taps     (taps),
    .taps_vld (taps_vld),
    .ir_bits  (ir_bits),
    .ir_vld   (ir_vld),
    .dr_bits  (dr_bits),
    .dr_vld   (dr_vld)
  );

  AST_DONE_WHEN_IDLE: assert property (@(posedge clk) disable iff (!srst_n)
    done |-> (!busy && !tck)); // R8

endmodule

// File: tb/jchain_probe_test.sv
`timescale 1ns/1ps
module jchain_probe_test;

  localparam int FILL = 48;
  localparam int MAXC = 40;
  localparam int CW   = $clog2(MAXC + 1);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [1:0] op = 2'd0;
  logic tck, tms, tdi, tdo;
  logic done, timeout, taps_vld, ir_vld, dr_vld;
  logic [CW-1:0] taps, ir_bits, dr_bits;

  always #5 clk = ~clk;

  jchain_probe #(.FILL_LEN(FILL), .MAX_COUNT(MAXC)) uut (
    .clk(clk), .rst_n(rst_n), .start(start), .op(op),
    .tck(tck), .tms(tms), .tdi(tdi), .tdo(tdo),
    .done(done), .timeout(timeout),
    .taps(taps), .taps_vld(taps_vld),
    .ir_bits(ir_bits), .ir_vld(ir_vld),
    .dr_bits(dr_bits), .dr_vld(dr_vld)
  );

  int nchk = 0;
  int nfail = 0;

  // ---------------- chain model ----------------
  localparam int TLR = 0, RTI = 1, SELDR = 2, CAPDR = 3, SHDR = 4, EX1DR = 5,
                 PADR = 6, EX2DR = 7, UPDR = 8, SELIR = 9, CAPIR = 10,
                 SHIR = 11, EX1IR = 12, PAIR = 13, EX2IR = 14, UPIR = 15;

  logic trst = 1'b0;
  int   st;
  int   n_taps = 1;
  int   irl[4];
  int   dl[4];
  logic [63:0] irv, drv;
  logic [3:0]  byp;
  logic tdo_m = 1'b0;
  logic stuck_en = 1'b0;
  logic stuck_v = 1'b0;

  assign tdo = stuck_en ? stuck_v : tdo_m;

  function automatic int nxt(input int s, input logic m);
    case (s)
      TLR:   return m ? TLR   : RTI;
      RTI:   return m ? SELDR : RTI;
      SELDR: return m ? SELIR : CAPDR;
      CAPDR: return m ? EX1DR : SHDR;
      SHDR:  return m ? EX1DR : SHDR;
      EX1DR: return m ? UPDR  : PADR;
      PADR:  return m ? EX2DR : PADR;
      EX2DR: return m ? UPDR  : SHDR;
      UPDR:  return m ? SELDR : RTI;
      SELIR: return m ? TLR   : CAPIR;
      CAPIR: return m ? EX1IR : SHIR;
      SHIR:  return m ? EX1IR : SHIR;
      EX1IR: return m ? UPIR  : PAIR;
      PAIR:  return m ? EX2IR : PAIR;
      EX2IR: return m ? UPIR  : SHIR;
      default: return m ? SELDR : RTI;
    endcase
  endfunction

  function automatic int ir_total();
    int t = 0;
    for (int d = 0; d < n_taps; d++) t += irl[d];
    return t;
  endfunction

  function automatic int dr_total();
    int t = 0;
    for (int d = 0; d < n_taps; d++) t += byp[d] ? 1 : dl[d];
    return t;
  endfunction

  function automatic logic [63:0] cap_ir();
    logic [63:0] v = '0;
    int off = 0;
    for (int d = 0; d < n_taps; d++) begin
      v[off + irl[d] - 1] = 1'b1;
      off += irl[d];
    end
    return v;
  endfunction

  function automatic logic [3:0] upd_ir();
    logic [3:0] b = '0;
    int off = 0;
    for (int d = 0; d < n_taps; d++) begin
      b[d] = 1'b1;
      for (int k = 0; k < irl[d]; k++) b[d] &= irv[off + k];
      off += irl[d];
    end
    return b;
  endfunction

  always @(posedge tck or posedge trst) begin
    if (trst) begin
      st  <= TLR;
      byp <= '0;
      irv <= '0;
      drv <= '0;
    end else begin
      case (st)
        TLR:   byp <= '0;
        CAPIR: irv <= cap_ir();
        SHIR:  irv <= {irv[62:0], tdi};
        UPIR:  byp <= upd_ir();
        CAPDR: drv <= '0;
        SHDR:  drv <= {drv[62:0], tdi};
        default: ;
      endcase
      st <= nxt(st, tms);
    end
  end

  always @(negedge tck) begin
    if (st == SHIR)      tdo_m <= irv[ir_total() - 1];
    else if (st == SHDR) tdo_m <= drv[dr_total() - 1];
  end

  // ---------------- pin timing monitor (R6) ----------------
  int   viol = 0;
  int   hi_w = 0, lo_w = 0;
  logic p_tck = 1'b0, p_tms = 1'b0, p_tdi = 1'b0;
  logic mon_on = 1'b0;

  always @(negedge clk) begin
    if (mon_on) begin
      if (tck && (tms !== p_tms || tdi !== p_tdi)) viol++;
      if (tck && !p_tck && lo_w < 2) viol++;
      if (!tck && p_tck && hi_w != 2) viol++;
      if (tck) begin
        hi_w = p_tck ? hi_w + 1 : 1;
        lo_w = 0;
      end else begin
        lo_w = p_tck ? 1 : lo_w + 1;
        hi_w = 0;
      end
    end
    p_tck = tck;
    p_tms = tms;
    p_tdi = tdi;
  end

  // ---------------- helpers ----------------
  task automatic chk(input string req, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  task automatic run_op(input logic [1:0] m, input string req);
    int w = 0;
    @(negedge clk);
    start = 1'b1;
    op    = m;
    @(negedge clk);
    start = 1'b0;
    while (!done && w < 20000) begin
      @(negedge clk);
      w++;
    end
    chk({req, " done seen"}, int'(done), 1);
  endtask

  task automatic after_done(input string req);
    chk({req, " R7 chain in Run-Test/Idle"}, st, RTI);
    @(negedge clk);
    chk({req, " R8 done is one cycle"}, int'(done), 0);
  endtask

  // ---------------- watchdog ----------------
  initial begin
    repeat (190000) @(posedge clk);
    nfail++;
    $display("FAIL R8 watchdog act=expired exp=finished");
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  // ---------------- stimulus ----------------
  initial begin
    int sum_ir, sum_dr;
    logic [CW-1:0] keep;
    int dn, rises;
    logic pt;

    trst = 1'b1;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    trst  = 1'b0;
    repeat (4) @(negedge clk);

    // R11 reset state
    chk("R11 tck",   int'(tck), 0);
    chk("R11 tms",   int'(tms), 0);
    chk("R11 tdi",   int'(tdi), 0);
    chk("R11 done",  int'(done), 0);
    chk("R11 timeout", int'(timeout), 0);
    chk("R11 results", int'(taps) + int'(ir_bits) + int'(dr_bits), 0);
    chk("R11 valids",  int'(taps_vld) + int'(ir_vld) + int'(dr_vld), 0);
    mon_on = 1'b1;

    // sweep of chain shapes
    for (int cfg = 0; cfg < 8; cfg++) begin
      n_taps = cfg % 4 + 1;
      for (int d = 0; d < 4; d++) begin
        irl[d] = 2 + ((d * 3 + cfg) % 5);
        dl[d]  = 1 + ((d * 5 + cfg * 3) % 8);
      end
      sum_ir = 0;
      sum_dr = 0;
      for (int d = 0; d < n_taps; d++) begin
        sum_ir += irl[d];
        sum_dr += dl[d];
      end
      @(negedge clk); trst = 1'b1;
      @(negedge clk); trst = 1'b0;

      run_op(2'd2, "R3 data after reset");
      chk("R3 dr_bits data regs", int'(dr_bits), sum_dr);
      chk("R3 dr_vld", int'(dr_vld), 1);
      chk("R4 timeout clear", int'(timeout), 0);
      after_done("R3");

      run_op(2'd1, "R2 ir");
      chk("R2 ir_bits", int'(ir_bits), sum_ir);
      chk("R2 ir_vld", int'(ir_vld), 1);
      chk("R10 dr kept after ir", int'(dr_bits), sum_dr);
      after_done("R2");

      run_op(2'd2, "R3 data after ir");
      chk("R3 dr_bits bypass", int'(dr_bits), n_taps);
      after_done("R3");

      keep = ir_bits;
      run_op(2'd0, "R1 taps");
      chk("R1 taps", int'(taps), n_taps);
      chk("R1 taps_vld", int'(taps_vld), 1);
      chk("R10 ir kept after taps", int'(ir_bits), int'(keep));
      after_done("R1");
    end

    // R5 boundary: single data register of MAXC then MAXC+1 bits
    n_taps = 1; irl[0] = 4; dl[0] = MAXC;
    @(negedge clk); trst = 1'b1;
    @(negedge clk); trst = 1'b0;
    run_op(2'd2, "R5 at limit");
    chk("R5 dr_bits at limit", int'(dr_bits), MAXC);
    chk("R5 valid at limit", int'(dr_vld), 1);
    chk("R5 no timeout at limit", int'(timeout), 0);
    after_done("R5");
    dl[0] = MAXC + 1;
    @(negedge clk); trst = 1'b1;
    @(negedge clk); trst = 1'b0;
    run_op(2'd2, "R5 over limit");
    chk("R5 timeout over limit", int'(timeout), 1);
    chk("R5 dr_bits zero", int'(dr_bits), 0);
    chk("R5 dr_vld zero", int'(dr_vld), 0);
    after_done("R5");

    // R4 timeouts with stuck TDO, both marker polarities
    n_taps = 2; irl[0] = 3; irl[1] = 5; dl[0] = 4; dl[1] = 6;
    @(negedge clk); trst = 1'b1;
    @(negedge clk); trst = 1'b0;
    run_op(2'd0, "R1 taps before stuck");
    chk("R1 taps two", int'(taps), 2);
    after_done("R1");
    stuck_en = 1'b1; stuck_v = 1'b1;
    run_op(2'd1, "R4 ir stuck high");
    chk("R4 timeout ir", int'(timeout), 1);
    chk("R4 ir_bits zero", int'(ir_bits), 0);
    chk("R4 ir_vld zero", int'(ir_vld), 0);
    chk("R10 taps kept on ir timeout", int'(taps), 2);
    after_done("R4");
    stuck_v = 1'b0;
    run_op(2'd0, "R4 taps stuck low");
    chk("R4 timeout taps", int'(timeout), 1);
    chk("R4 taps zero", int'(taps), 0);
    chk("R4 taps_vld zero", int'(taps_vld), 0);
    after_done("R4");
    stuck_en = 1'b0;

    // R9 start while busy is ignored
    @(negedge clk); trst = 1'b1;
    @(negedge clk); trst = 1'b0;
    @(negedge clk); start = 1'b1; op = 2'd0;
    @(negedge clk); start = 1'b0;
    repeat (30) @(negedge clk);
    start = 1'b1; op = 2'd1;
    @(negedge clk); start = 1'b0;
    dn = 0;
    for (int w = 0; w < 20000 && dn == 0; w++) begin
      @(negedge clk);
      if (done) dn++;
    end
    chk("R9 first run done", dn, 1);
    chk("R9 taps from first run", int'(taps), 2);
    chk("R9 ir untouched", int'(ir_vld), 0);
    dn = 0;
    rises = 0;
    pt = tck;
    repeat (600) begin
      @(negedge clk);
      if (done) dn++;
      if (tck && !pt) rises++;
      pt = tck;
    end
    chk("R9 no second done", dn, 0);
    chk("R9 no tck after busy start", rises, 0);

    // R9 unused operation code
    @(negedge clk); start = 1'b1; op = 2'd3;
    @(negedge clk); start = 1'b0;
    dn = 0;
    rises = 0;
    pt = tck;
    repeat (60) begin
      @(negedge clk);
      if (done) dn++;
      if (tck && !pt) rises++;
      pt = tck;
    end
    chk("R9 op3 no done", dn, 0);
    chk("R9 op3 no tck", rises, 0);

    chk("R6 pin timing violations", viol, 0);
    chk("R6 tck low idle", int'(tck), 0);

    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

endmodule